// File: doc/BRIEF.md
# Protected Address Translation Buffer

This block is a small, fully associative cache of page translations that sits beside a load/store or fetch unit. Each cycle it may be presented with a virtual address, an intent (read or write) and the privilege of the requester. In that same cycle it answers with exactly one of three outcomes: a translated physical address (hit), a request for a page table walk (miss), or a permission violation (fault). A fault is reported apart from a miss and never comes with an address.

An entry maps either a normal 4 KiB page or a large 4 MiB page. For a large page only the top ten bits of the virtual page number are compared, and the low 22 address bits pass through to the output unchanged. Entries are written by an external walker through a refill port. The walker's data goes into the lowest free slot, or into a round-robin victim once all slots are full. A flush input empties the whole buffer in one cycle. A write that hits a clean entry marks that entry dirty.

Top module: `tlb_prot`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss and no hit or fault.
- R2: A lookup whose page number equals a valid normal-page entry's tag, and which passes the permission check, raises hit combinationally in the same cycle with lk_pa = {entry PPN, lk_va[11:0]}.
- R3: For a valid entry with the large flag set, only lk_va[31:22] is compared with tag bits [19:10]; on a permitted hit lk_pa = {PPN[19:10], lk_va[21:0]}, and tag bits [9:0] and PPN bits [9:0] have no effect.
- R4: A valid lookup that matches no entry raises miss only, with lk_pa zero. With lk_valid low, hit, miss, fault and dirty are all 0. At most one of hit, miss and fault is high.
- R5: In user mode (lk_user=1) a read needs the entry's read bit and a write needs its write bit. A violation raises fault only, with lk_pa zero.
- R6: In kernel mode (lk_user=0) a matching lookup always hits, whatever the read and write bits are.
- R7: lk_dirty shows the dirty bit of the entry that hit. A write that hits (not one that faults) sets that bit from the next cycle onward, and a refill of the same slot in the same cycle takes precedence.
- R8: A refill writes the lowest-index invalid slot. When all slots are valid it overwrites the slot named by a round-robin pointer, which starts at 0, advances by one per such replacement and wraps after the last slot.
- R9: Flush clears every valid bit at the next edge and resets the round-robin pointer to 0. A refill in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_pa | output | 32 | Physical address, zero unless hit |
| lk_hit | output | 1 | Translation delivered |
| lk_miss | output | 1 | No matching entry; walk required |
| lk_fault | output | 1 | Matching entry denies this access |
| lk_dirty | output | 1 | Dirty bit of the entry that hit |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 20 | Refill virtual page number (tag) |
| rf_ppn | input | 20 | Refill physical page number |
| rf_rd | input | 1 | Refill read permission |
| rf_wr | input | 1 | Refill write permission |
| rf_dirty | input | 1 | Refill initial dirty bit |
| rf_large | input | 1 | Refill entry maps a large page |
| flush | input | 1 | Invalidate all entries |

## Verification
Two operations can update the same slot in one cycle: a write hit marks it dirty while a refill selects it as the round-robin victim. The bench first brings the pointer to a known slot with a full buffer. It then issues a kernel write to that slot's page together with a refill, and expects the new mapping to read back clean while the old page misses. In the same way, flush is raised together with a refill, and the bench expects the refilled page to miss afterwards and later refills to start again from a cleared pointer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 32;
  localparam int OFS_W     = 12;
  localparam int LRG_OFS_W = 22;
  localparam int VPN_W     = VA_W - OFS_W;
  localparam int PPN_W     = PA_W - OFS_W;
  localparam int LRG_LOW_W = LRG_OFS_W - OFS_W;

  typedef struct packed {
    logic             v;
    logic             r;
    logic             w;
    logic             d;
    logic             l;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
(
  input  tlb_ent_t         ent,
  input  logic [VPN_W-1:0] vpn,
  output logic             hit
);
  logic hi_eq;
  logic lo_eq;

  always_comb begin
    hi_eq = (ent.vpn[VPN_W-1:LRG_LOW_W] == vpn[VPN_W-1:LRG_LOW_W]);
    lo_eq = (ent.vpn[LRG_LOW_W-1:0] == vpn[LRG_LOW_W-1:0]);
    hit   = ent.v & hi_eq & (ent.l | lo_eq);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int NUM_ENT = 8,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] valid_vec,
  input  logic               alloc,
  input  logic               clr,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] rr_d;
  logic [IDX_W-1:0] first_free;
  logic             full;
  logic             rr_en;

  always_comb begin
    first_free = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!valid_vec[i]) first_free = IDX_W'(i);
    end
    full   = &valid_vec;
    victim = full ? rr_q : first_free;
  end

  always_comb begin
    rr_d  = rr_q;
    rr_en = 1'b0;
    if (clr) begin
      rr_d  = '0;
      rr_en = 1'b1;
    end else if (alloc && full) begin
      rr_d  = (rr_q == IDX_W'(NUM_ENT - 1)) ? '0 : rr_q + 1'b1;
      rr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_en) rr_q <= rr_d;
  end

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !valid_vec[victim]); // R8
  AST_RR_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rr_q == '0)); // R9
endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
  import tlb_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             lk_write,
  input  logic             lk_user,
  output logic [PA_W-1:0]  lk_pa,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_fault,
  output logic             lk_dirty,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic             rf_rd,
  input  logic             rf_wr,
  input  logic             rf_dirty,
  input  logic             rf_large,
  input  logic             flush
);
  localparam int IDX_W = $clog2(NUM_ENT);

  tlb_ent_t           ents_q [NUM_ENT];
  tlb_ent_t           ents_d [NUM_ENT];
  logic [NUM_ENT-1:0] match_vec;
  logic [NUM_ENT-1:0] valid_vec;
  logic [NUM_ENT-1:0] dirty_vec;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim;
  tlb_ent_t           sel;
  logic               hit_any;
  logic               perm_ok;
  logic               dirty_set;
  logic               alloc;
  logic               upd_en;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    tlb_match u_match (
      .ent (ents_q[g]),
      .vpn (lk_va[VA_W-1:OFS_W]),
      .hit (match_vec[g])
    );
    assign valid_vec[g] = ents_q[g].v;
    assign dirty_vec[g] = ents_q[g].d;
  end

  assign alloc = rf_valid & ~flush;

  tlb_victim #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .alloc     (alloc),
    .clr       (flush),
    .victim    (victim)
  );

  // Lookup and permission check, all in the request cycle
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
    hit_any  = |match_vec;
    sel      = ents_q[hit_idx];
    perm_ok  = ~lk_user | (lk_write ? sel.w : sel.r);
    lk_hit   = lk_valid & hit_any & perm_ok;
    lk_fault = lk_valid & hit_any & ~perm_ok;
    lk_miss  = lk_valid & ~hit_any;
    lk_dirty = lk_hit & sel.d;
    if (!lk_hit)    lk_pa = '0;
    else if (sel.l) lk_pa = {sel.ppn[PPN_W-1:LRG_LOW_W], lk_va[LRG_OFS_W-1:0]};
    else            lk_pa = {sel.ppn, lk_va[OFS_W-1:0]};
  end

  // Entry next state: dirty marking, then refill, then flush (later wins)
  always_comb begin
    dirty_set = lk_hit & lk_write & ~sel.d;
    upd_en    = dirty_set | rf_valid | flush;
    for (int i = 0; i < NUM_ENT; i++) ents_d[i] = ents_q[i];
    if (dirty_set) ents_d[hit_idx].d = 1'b1;
    if (alloc) begin
      ents_d[victim].v   = 1'b1;
      ents_d[victim].r   = rf_rd;
      ents_d[victim].w   = rf_wr;
      ents_d[victim].d   = rf_dirty;
      ents_d[victim].l   = rf_large;
      ents_d[victim].vpn = rf_vpn;
      ents_d[victim].ppn = rf_ppn;
    end
    if (flush) begin
      for (int i = 0; i < NUM_ENT; i++) ents_d[i].v = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) ents_q[i] <= '0;
    end else if (upd_en) begin
      for (int i = 0; i < NUM_ENT; i++) ents_q[i] <= ents_d[i];
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_fault})); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit | lk_miss | lk_fault | lk_dirty)); // R4
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R2
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_pa == '0)); // R5
  AST_KERNEL_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_user |-> !lk_fault); // R6
  AST_DIRTY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit & lk_write & !rf_valid & !flush) |=> (($past(match_vec) & ~dirty_vec) == '0)); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0)); // R9
endmodule

// File: tb/tlb_prot_tb.sv
module tlb_prot_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_write, lk_user;
  logic [31:0] lk_va;
  logic [31:0] lk_pa;
  logic        lk_hit, lk_miss, lk_fault, lk_dirty;
  logic        rf_valid, rf_rd, rf_wr, rf_dirty, rf_large, flush;
  logic [19:0] rf_vpn, rf_ppn;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model built from the requirements
  bit          m_v [8];
  bit          m_r [8];
  bit          m_w [8];
  bit          m_d [8];
  bit          m_l [8];
  logic [19:0] m_vpn [8];
  logic [19:0] m_ppn [8];
  int          m_rr;

  always #2.5 clk = ~clk;

  tlb_prot u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_write(lk_write), .lk_user(lk_user),
    .lk_pa(lk_pa), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
    .lk_dirty(lk_dirty),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_rd(rf_rd),
    .rf_wr(rf_wr), .rf_dirty(rf_dirty), .rf_large(rf_large), .flush(flush)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(logic [31:0] va);
    for (int i = 0; i < 8; i++) begin
      if (m_v[i] && (m_l[i] ? (m_vpn[i][19:10] == va[31:22]) : (m_vpn[i] == va[31:12])))
        return i;
    end
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < 8; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic m_alloc(logic [19:0] vpn, logic [19:0] ppn, bit r, bit w, bit d, bit l);
    int vi = m_victim();
    if (vi < 0) begin
      vi   = m_rr;
      m_rr = (m_rr + 1) % 8;
    end
    m_v[vi] = 1; m_r[vi] = r; m_w[vi] = w; m_d[vi] = d; m_l[vi] = l;
    m_vpn[vi] = vpn; m_ppn[vi] = ppn;
  endtask

  task automatic m_clear();
    for (int i = 0; i < 8; i++) m_v[i] = 0;
    m_rr = 0;
  endtask

  // compare outputs against the model for the lookup currently driven
  task automatic expect_now(string tag, bit wr, bit user, output bit exp_hit, output int idx);
    bit ok, e_miss, e_fault, e_dirty;
    logic [31:0] e_pa;
    string req;
    idx = m_find(lk_va);
    ok = 0; e_miss = 0; e_fault = 0; e_dirty = 0; e_pa = '0;
    if (idx < 0) e_miss = 1;
    else begin
      ok = !user || (wr ? m_w[idx] : m_r[idx]);
      e_fault = !ok;
      if (ok) begin
        e_dirty = m_d[idx];
        e_pa = m_l[idx] ? {m_ppn[idx][19:10], lk_va[21:0]} : {m_ppn[idx], lk_va[11:0]};
      end
    end
    exp_hit = (idx >= 0) && ok;
    if (tag != "") req = tag;
    else if (idx < 0) req = "R4";
    else if (!ok) req = "R5";
    else if (!user) req = "R6";
    else if (m_l[idx]) req = "R3";
    else req = "R2";
    chk(req, "hit", 32'(lk_hit), 32'(exp_hit));
    chk(req, "miss", 32'(lk_miss), 32'(e_miss));
    chk(req, "fault", 32'(lk_fault), 32'(e_fault));
    chk(req, "pa", lk_pa, e_pa);
    chk("R7", "dirty", 32'(lk_dirty), 32'(e_dirty));
  endtask

  task automatic lookup(logic [31:0] va, bit wr, bit user, string tag);
    bit eh;
    int idx;
    @(negedge clk);
    lk_valid = 1; lk_va = va; lk_write = wr; lk_user = user;
    #1;
    expect_now(tag, wr, user, eh, idx);
    if (eh && wr) m_d[idx] = 1;
    @(posedge clk); #1;
    lk_valid = 0;
  endtask

  task automatic refill(logic [19:0] vpn, logic [19:0] ppn, bit r, bit w, bit d, bit l);
    @(negedge clk);
    rf_valid = 1; rf_vpn = vpn; rf_ppn = ppn; rf_rd = r; rf_wr = w; rf_dirty = d; rf_large = l;
    m_alloc(vpn, ppn, r, w, d, l);
    @(posedge clk); #1;
    rf_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit eh;
    int idx;
    logic [31:0] va;
    rst_n = 0; lk_valid = 0; lk_va = '0; lk_write = 0; lk_user = 0;
    rf_valid = 0; rf_vpn = '0; rf_ppn = '0; rf_rd = 0; rf_wr = 0;
    rf_dirty = 0; rf_large = 0; flush = 0;
    m_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: empty after reset
    lookup(32'h0000_0000, 0, 0, "R1");
    lookup(32'h1000_0123, 1, 1, "R1");
    lookup(32'hFFFF_FFFF, 0, 1, "R1");

    // six normal pages covering every read/write combination, two large pages
    for (int i = 0; i < 6; i++)
      refill(20'h10000 + 20'(i * 17), 20'hA0000 + 20'(i * 3), i[0], i[1], 0, 0);
    for (int i = 6; i < 8; i++)
      refill({10'h300 + 10'(i - 6), 10'h0}, {10'h2A0 + 10'(i), 10'h3FF}, 1, (i == 7), 0, 1);

    // R4: idle lookup port is quiet even when the address would hit
    @(negedge clk);
    lk_valid = 0; lk_va = {m_vpn[0], 12'h0}; #1;
    chk("R4", "idle flags", {28'h0, lk_hit, lk_miss, lk_fault, lk_dirty}, 32'h0);

    // sweep every entry across mode, intent and offset patterns
    for (int e = 0; e < 8; e++)
      for (int u = 0; u < 2; u++)
        for (int wr = 0; wr < 2; wr++)
          for (int k = 0; k < 3; k++) begin
            if (m_l[e]) va = {m_vpn[e][19:10], 10'(k * 309 + e), 12'(k * 1447)};
            else        va = {m_vpn[e], 12'(k * 1447 + e)};
            lookup(va, wr[0], u[0], "");
          end

    // R4: misses, including a normal page differing only in its low tag bit
    for (int k = 0; k < 6; k++) lookup({20'h7F000 + 20'(k), 12'h0}, k[0], k[1], "R4");
    lookup({m_vpn[0] ^ 20'h1, 12'h0}, 0, 0, "R4");

    // R8: full buffer, round-robin evicts slot 0 then slot 1
    refill(20'h55000, 20'hC0000, 1, 1, 0, 0);
    refill(20'h55001, 20'hC0001, 1, 1, 0, 0);
    lookup({20'h10000, 12'h004}, 0, 0, "R8");
    lookup({20'h10011, 12'h004}, 0, 0, "R8");
    lookup({20'h55000, 12'h008}, 0, 0, "R8");
    lookup({20'h55001, 12'h00C}, 0, 0, "R8");

    // R7: kernel write hit on the next victim while a refill replaces it
    @(negedge clk);
    lk_valid = 1; lk_va = {m_vpn[m_rr], 12'h010}; lk_write = 1; lk_user = 0;
    rf_valid = 1; rf_vpn = 20'h66000; rf_ppn = 20'hB1234; rf_rd = 1; rf_wr = 1;
    rf_dirty = 0; rf_large = 0;
    #1;
    expect_now("R7", 1, 0, eh, idx);
    if (eh) m_d[idx] = 1;
    m_alloc(20'h66000, 20'hB1234, 1, 1, 0, 0);
    @(posedge clk); #1;
    lk_valid = 0; rf_valid = 0;
    lookup({20'h66000, 12'h020}, 0, 0, "R7");
    lookup({20'h10022, 12'h020}, 0, 0, "R8");

    // R9: flush beats a refill in the same cycle
    @(negedge clk);
    flush = 1; rf_valid = 1; rf_vpn = 20'h77000; rf_ppn = 20'hD0000;
    rf_rd = 1; rf_wr = 1; rf_dirty = 0; rf_large = 0;
    m_clear();
    @(posedge clk); #1;
    flush = 0; rf_valid = 0;
    lookup({20'h77000, 12'h0}, 0, 0, "R9");
    lookup({20'h66000, 12'h0}, 0, 0, "R9");
    lookup({10'h301, 10'h155, 12'h0}, 0, 0, "R9");

    // R9: pointer restarts at slot 0 after refilling to full
    for (int i = 0; i < 8; i++) refill(20'h20000 + 20'(i), 20'hE0000 + 20'(i), 1, 1, 0, 0);
    refill(20'h30000, 20'hF0000, 1, 1, 1, 0);
    lookup({20'h20000, 12'h0}, 0, 0, "R9");
    lookup({20'h20001, 12'h0}, 0, 0, "R9");
    lookup({20'h30000, 12'hABC}, 1, 1, "R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule